// File: doc/BRIEF.md
# Capture-Compare General-Purpose Timer

This block is a 16-bit up-counter with a compare (reference) register, a capture register and sticky event flags, reached through a simple synchronous read/write register bus. The count advances on a "tick" made in two stages. First a clock source is picked: none, every system clock, one system clock in sixteen, or each falling edge of an asynchronous external clock pin. An 8-bit prescaler then divides that source by its programmed value plus one.

When a tick arrives while the count equals the reference, the timer records a reference event. It then drives its output pin, either as a one-clock low pulse or as a toggle, and either keeps counting upward or returns to zero. A second asynchronous pin can latch the count on a rising edge, a falling edge or either edge. A single interrupt line combines the reference event, gated by its own enable, with the capture event, which is enabled by any nonzero capture-edge code. Software clears events by writing ones to the event register.

Register word map (byte addresses; bits [1:0] of the address must be zero): 0x00 mode, 0x04 reference, 0x08 capture (read-only), 0x0C counter (any write clears it), 0x10 events. Mode word fields: [15:8] prescaler, [7:6] capture edge, [5] output toggle, [4] reference interrupt enable, [3] restart on reference, [2:1] clock source, [0] run.

Top module: `gp_capture_timer`

## Requirements
- R1: After reset, every register reads zero, `tmr_out` is 1 and `irq` is 0.
- R2: With clock source 01 and prescaler value P in mode[15:8], the count rises by one every P+1 system clocks. P=0 advances it every clock and P=255 advances it every 256 clocks.
- R3: Clock source 00 never advances the count. Source 10 gives one prescaler input per 16 clocks, the first one 16 clocks after the run bit is set. Source 11 gives one per falling edge of `ext_clk_in`, which takes effect 3 clocks after the edge.
- R4: While mode[0] is 0 the count, prescaler and divide-by-16 stage are held at zero, so the counter reads 0.
- R5: A tick while the count equals the reference sets event bit 1. With mode[3]=0 the count then goes on to reference+1. With mode[3]=1 it goes to 0.
- R6: With mode[5]=0, `tmr_out` is low for exactly the one clock after a reference event. With mode[5]=1 it inverts on each reference event and otherwise holds its level.
- R7: Capture-edge code mode[7:6] selects the edge: 00 none, 01 rising only, 10 falling only, 11 both. A selected edge on `cap_in` loads the current count into the capture register and sets event bit 0, 3 clocks after the pin changes.
- R8: `irq` = (event bit 1 AND mode[4]) OR (event bit 0 AND mode[7:6]≠00). Setting mode[4] while event bit 1 is already set raises `irq` at once.
- R9: Writing 1 to an event bit clears it. A new event in the same clock as the clearing write leaves the bit set.
- R10: Any write to the counter address sets the count to 0 on that clock. Writes to the capture address change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational from bus_addr) |
| ext_clk_in | input | 1 | Asynchronous external count clock, falling edges counted |
| cap_in | input | 1 | Asynchronous capture trigger |
| tmr_out | output | 1 | Compare output, high out of reset |
| irq | output | 1 | Interrupt request |

## Verification
The race that matters is a reference event landing in the same clock as a software write that clears the reference flag. The bench restarts the counter with a reference of 5 and a prescaler of zero, so the event is known to occur on the sixth edge after the run bit is written. It places the clearing write on exactly that edge and expects the flag to read back as 1. A second write one edge later must then clear the flag. The capture path has a matching assertion for a capture edge meeting a clearing write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int BUS_W = 16;
  localparam int PS_W  = 8;

  // register word indices (byte address / 4)
  localparam int REG_MODE = 0;
  localparam int REG_REF  = 1;
  localparam int REG_CAP  = 2;
  localparam int REG_CNT  = 3;
  localparam int REG_EVT  = 4;

  typedef enum logic [1:0] {
    CS_STOP  = 2'b00,
    CS_SYS   = 2'b01,
    CS_DIV16 = 2'b10,
    CS_EXT   = 2'b11
  } clk_src_e;

  typedef enum logic [1:0] {
    CE_OFF  = 2'b00,
    CE_RISE = 2'b01,
    CE_FALL = 2'b10,
    CE_BOTH = 2'b11
  } cap_edge_e;

  typedef struct packed {
    logic [PS_W-1:0] ps;
    logic [1:0]      cap_edge;
    logic            out_toggle;
    logic            ref_ie;
    logic            restart;
    logic [1:0]      clk_src;
    logic            run;
  } mode_t;

  function automatic logic edge_selected(input logic [1:0] code,
                                         input logic rise, input logic fall);
    case (code)
      CE_RISE: return rise;
      CE_FALL: return fall;
      CE_BOTH: return rise | fall;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              prev;
  logic              level;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign level = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= RST_VAL;
    else        prev <= level;

  assign rise = level & ~prev;
  assign fall = ~level & prev;

  // R7: a detected edge cannot repeat in the next cycle
  a_r7_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) |=> !(rise && $past(rise)) && !(fall && $past(fall)));

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV_W = 4,
  parameter int PS_W  = tmr_pkg::PS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [1:0]      clk_src,
  input  logic [PS_W-1:0] ps,
  input  logic            ext_fall,
  output logic            tick
);
  import tmr_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic [PS_W-1:0]  pcnt_q;
  logic             div_pulse;
  logic             src_pulse;
  logic             presc_wrap;

  // prescaler reaches its terminal value; >= keeps it safe when ps shrinks
  function automatic logic presc_last(input logic [PS_W-1:0] c,
                                      input logic [PS_W-1:0] lim);
    return c >= lim;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   div_q <= '0;
    else if (!run) div_q <= '0;
    else          div_q <= div_q + 1'b1;

  assign div_pulse = run && (div_q == {DIV_W{1'b1}});

  always_comb begin
    case (clk_src)
      CS_SYS:   src_pulse = run;
      CS_DIV16: src_pulse = div_pulse;
      CS_EXT:   src_pulse = run && ext_fall;
      default:  src_pulse = 1'b0;
    endcase
  end

  assign presc_wrap = presc_last(pcnt_q, ps);
  assign tick       = src_pulse && presc_wrap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         pcnt_q <= '0;
    else if (!run)      pcnt_q <= '0;
    else if (src_pulse) pcnt_q <= presc_wrap ? '0 : pcnt_q + 1'b1;

  // R4: no tick leaves a stopped timer
  a_r4_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
  // R3: source code 00 never ticks
  a_r3_stop_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src == CS_STOP) |-> !tick);
  // R2: with divide-by-one the tick follows every running cycle
  a_r2_div_one: assert property (@(posedge clk) disable iff (!rst_n)
    (run && clk_src == CS_SYS && ps == '0) |-> tick);

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             cnt_clr,
  input  logic             restart,
  input  logic             out_toggle,
  input  logic [CNT_W-1:0] ref_val,
  output logic [CNT_W-1:0] count,
  output logic             ref_hit,
  output logic             tmr_out
);

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic wrap);
    return wrap ? '0 : c + 1'b1;
  endfunction

  assign ref_hit = tick && !cnt_clr && (count == ref_val);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              count <= '0;
    else if (!run || cnt_clr) count <= '0;
    else if (tick)           count <= next_count(count, ref_hit && restart);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           tmr_out <= 1'b1;
    else if (ref_hit)     tmr_out <= out_toggle ? ~tmr_out : 1'b0;
    else if (!out_toggle) tmr_out <= 1'b1;

  // R5: restart mode returns to zero after a reference event
  a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hit && restart) |=> (count == '0));
  // R5: free-run mode steps past the reference
  a_r5_free_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hit && !restart) |=> (count == $past(ref_val) + 1'b1));
  // R10: a counter write leaves zero
  a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (count == '0));
  // R6: pulse mode drives low for one clock then releases
  a_r6_pulse_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hit && !out_toggle) |=> !tmr_out);
  a_r6_pulse_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_toggle && !tmr_out && !ref_hit) |=> tmr_out);
  // R6: toggle mode inverts on each event
  a_r6_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hit && out_toggle) |=> (tmr_out != $past(tmr_out)));

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [tmr_pkg::BUS_W-1:0] bus_wdata,
  output logic [tmr_pkg::BUS_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]          count,
  input  logic                      ref_hit,
  input  logic                      cap_rise,
  input  logic                      cap_fall,
  output tmr_pkg::mode_t            mode,
  output logic [CNT_W-1:0]          ref_val,
  output logic                      cnt_clr,
  output logic                      irq
);
  import tmr_pkg::*;

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             wr;
  logic             wr_evt;
  logic             cap_evt;
  logic [CNT_W-1:0] cap_q;
  logic             ref_flag;
  logic             cap_flag;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr      = bus_sel && bus_we && aligned;
  assign wr_evt  = wr && (idx == IDX_W'(REG_EVT));
  assign cnt_clr = wr && (idx == IDX_W'(REG_CNT));
  assign cap_evt = edge_selected(mode.cap_edge, cap_rise, cap_fall);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode    <= '0;
      ref_val <= '0;
    end else if (wr) begin
      if (idx == IDX_W'(REG_MODE)) mode    <= mode_t'(bus_wdata);
      if (idx == IDX_W'(REG_REF))  ref_val <= bus_wdata[CNT_W-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cap_q <= '0;
    else if (cap_evt) cap_q <= count;

  // event flags: a new event wins over a clearing write
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_flag <= 1'b0;
      cap_flag <= 1'b0;
    end else begin
      ref_flag <= ref_hit || (ref_flag && !(wr_evt && bus_wdata[1]));
      cap_flag <= cap_evt || (cap_flag && !(wr_evt && bus_wdata[0]));
    end

  assign irq = (ref_flag && mode.ref_ie) ||
               (cap_flag && (mode.cap_edge != CE_OFF));

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (int'(idx))
        REG_MODE: bus_rdata = BUS_W'(mode);
        REG_REF:  bus_rdata = BUS_W'(ref_val);
        REG_CAP:  bus_rdata = BUS_W'(cap_q);
        REG_CNT:  bus_rdata = BUS_W'(count);
        REG_EVT:  bus_rdata = BUS_W'({ref_flag, cap_flag});
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R9: set beats clear on the same edge
  a_r9_ref_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ref_hit |=> ref_flag);
  a_r9_cap_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag);
  // R9: a clearing write with no new event drops the flag
  a_r9_ref_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && bus_wdata[1] && !ref_hit) |=> !ref_flag);
  // R7/R10: the capture register moves only on a capture event
  a_r7_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_q));

endmodule

// File: rtl/gp_capture_timer.sv
module gp_capture_timer #(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 5,
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [tmr_pkg::BUS_W-1:0] bus_wdata,
  output logic [tmr_pkg::BUS_W-1:0] bus_rdata,
  input  logic                      ext_clk_in,
  input  logic                      cap_in,
  output logic                      tmr_out,
  output logic                      irq
);
  import tmr_pkg::*;

  mode_t            mode;
  logic [CNT_W-1:0] ref_val;
  logic [CNT_W-1:0] count;
  logic             cnt_clr;
  logic             ref_hit;
  logic             tick;
  logic             ext_rise;
  logic             ext_fall;
  logic             cap_rise;
  logic             cap_fall;

  tmr_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_clk_in), .rise(ext_rise), .fall(ext_fall)
  );

  tmr_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(cap_rise), .fall(cap_fall)
  );

  tmr_tick_gen #(.DIV_W(DIV_W), .PS_W(PS_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(mode.run), .clk_src(mode.clk_src),
    .ps(mode.ps), .ext_fall(ext_fall), .tick(tick)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(mode.run), .tick(tick), .cnt_clr(cnt_clr),
    .restart(mode.restart), .out_toggle(mode.out_toggle), .ref_val(ref_val),
    .count(count), .ref_hit(ref_hit), .tmr_out(tmr_out)
  );

  tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count(count), .ref_hit(ref_hit), .cap_rise(cap_rise), .cap_fall(cap_fall),
    .mode(mode), .ref_val(ref_val), .cnt_clr(cnt_clr), .irq(irq)
  );

  // R3: an external rising edge never counts on its own
  a_r3_ext_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.clk_src == CS_EXT && ext_rise) |-> !tick);

endmodule

// File: tb/gp_capture_timer_tb.sv
module gp_capture_timer_tb_top;

  localparam logic [4:0] A_MODE = 5'h00;
  localparam logic [4:0] A_REF  = 5'h04;
  localparam logic [4:0] A_CAP  = 5'h08;
  localparam logic [4:0] A_CNT  = 5'h0C;
  localparam logic [4:0] A_EVT  = 5'h10;

  typedef struct packed {
    logic [15:0] mode;
    logic [15:0] cycles;
    logic [15:0] expect_cnt;
  } vec_t;

  // mode = ps<<8 | src<<1 | run
  localparam vec_t VECS [8] = '{
    '{16'h0003, 16'd20,  16'd20},  // R2 ps=0
    '{16'h0303, 16'd20,  16'd5},   // R2 ps=3
    '{16'h0403, 16'd23,  16'd4},   // R2 ps=4
    '{16'h0005, 16'd40,  16'd2},   // R3 div16, ps=0
    '{16'h0105, 16'd70,  16'd2},   // R3 div16, ps=1
    '{16'h0001, 16'd30,  16'd0},   // R3 stopped source
    '{16'hFF03, 16'd600, 16'd2},   // R2 ps=255
    '{16'h0002, 16'd10,  16'd0}    // R4 run bit clear
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ext_clk_in = 1'b1;
  logic        cap_in = 1'b0;
  logic        tmr_out;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [15:0] rv;
  logic [15:0] cap_val;

  always #4 clk = ~clk;

  gp_capture_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk_in(ext_clk_in), .cap_in(cap_in), .tmr_out(tmr_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // called at a falling edge; the write occurs on the next rising edge
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(A_MODE, rv); chk("R1 mode", rv, 16'h0);
    rd(A_REF, rv);  chk("R1 ref", rv, 16'h0);
    rd(A_CAP, rv);  chk("R1 cap", rv, 16'h0);
    rd(A_CNT, rv);  chk("R1 cnt", rv, 16'h0);
    rd(A_EVT, rv);  chk("R1 evt", rv, 16'h0);
    chk("R1 out", {15'd0, tmr_out}, 16'd1);
    chk("R1 irq", {15'd0, irq}, 16'd0);

    // table of count-rate vectors (R2, R3, R4)
    wr(A_REF, 16'hFFFF);
    for (int i = 0; i < 8; i++) begin
      wr(A_MODE, 16'h0000);
      wr(A_MODE, VECS[i].mode);
      idle(int'(VECS[i].cycles));
      rd(A_CNT, rv);
      chk("R2/R3/R4 rate vector", rv, VECS[i].expect_cnt);
    end

    // R3 external falling edges
    wr(A_MODE, 16'h0000);
    wr(A_MODE, 16'h0007);
    for (int k = 0; k < 5; k++) begin
      ext_clk_in = 1'b0; idle(2);
      ext_clk_in = 1'b1; idle(2);
    end
    idle(4);
    rd(A_CNT, rv); chk("R3 ext edges", rv, 16'd5);

    // R10 counter write clears while running
    wr(A_MODE, 16'h0003);
    idle(10);
    wr(A_CNT, 16'h5555);
    rd(A_CNT, rv); chk("R10 cnt clear", rv, 16'd0);

    // R5/R6 restart + pulse, reference 5
    wr(A_REF, 16'd5);
    wr(A_EVT, 16'h3);
    wr(A_MODE, 16'h0000);
    wr(A_MODE, 16'h000B);
    idle(5);
    rd(A_CNT, rv); chk("R5 before hit", rv, 16'd5);
    chk("R6 high before hit", {15'd0, tmr_out}, 16'd1);
    idle(1);
    rd(A_CNT, rv); chk("R5 restart to zero", rv, 16'd0);
    chk("R6 pulse low", {15'd0, tmr_out}, 16'd0);
    rd(A_EVT, rv); chk("R5 ref flag", rv, 16'h2);
    chk("R8 irq gated off", {15'd0, irq}, 16'd0);
    idle(1);
    chk("R6 pulse ends", {15'd0, tmr_out}, 16'd1);
    rd(A_CNT, rv); chk("R5 count after restart", rv, 16'd1);
    wr(A_MODE, 16'h0019);
    chk("R8 enable with flag set", {15'd0, irq}, 16'd1);
    wr(A_EVT, 16'h2);
    rd(A_EVT, rv); chk("R9 clear ref", rv, 16'h0);
    chk("R8 irq drops", {15'd0, irq}, 16'd0);

    // R9 set wins over clear on the same edge (free run, ref 5)
    wr(A_MODE, 16'h0000);
    wr(A_MODE, 16'h0003);
    idle(5);
    wr(A_EVT, 16'h2);
    rd(A_EVT, rv); chk("R9 set wins", rv, 16'h2);
    rd(A_CNT, rv); chk("R5 free run past ref", rv, 16'd6);
    wr(A_EVT, 16'h2);
    rd(A_EVT, rv); chk("R9 later clear", rv, 16'h0);

    // R6 toggle mode, ref 3
    wr(A_REF, 16'd3);
    wr(A_MODE, 16'h0000);
    wr(A_MODE, 16'h0023);
    idle(4);
    chk("R6 toggled", {15'd0, tmr_out}, 16'd0);
    rd(A_CNT, rv); chk("R5 free run count", rv, 16'd4);
    idle(6);
    chk("R6 toggle holds", {15'd0, tmr_out}, 16'd0);

    // R7 capture edges
    wr(A_REF, 16'hFFFF);
    wr(A_EVT, 16'h3);
    wr(A_MODE, 16'h0000);
    wr(A_MODE, 16'h0003);
    idle(6);
    wr(A_MODE, 16'h0041);
    rd(A_CNT, cap_val);
    chk("R2 frozen count", cap_val, 16'd7);
    cap_in = 1'b1; idle(3);
    rd(A_CAP, rv); chk("R7 captured value", rv, cap_val);
    rd(A_EVT, rv); chk("R7 rise flag", rv, 16'h1);
    chk("R8 capture irq", {15'd0, irq}, 16'd1);
    wr(A_EVT, 16'h1);
    cap_in = 1'b0; idle(3);
    rd(A_EVT, rv); chk("R7 rise-only ignores fall", rv, 16'h0);
    wr(A_MODE, 16'h0081);
    cap_in = 1'b1; idle(3);
    rd(A_EVT, rv); chk("R7 fall-only ignores rise", rv, 16'h0);
    cap_in = 1'b0; idle(3);
    rd(A_EVT, rv); chk("R7 fall flag", rv, 16'h1);
    wr(A_EVT, 16'h1);
    wr(A_MODE, 16'h00C1);
    cap_in = 1'b1; idle(3);
    rd(A_EVT, rv); chk("R7 both rise", rv, 16'h1);
    wr(A_EVT, 16'h1);
    cap_in = 1'b0; idle(3);
    rd(A_EVT, rv); chk("R7 both fall", rv, 16'h1);
    wr(A_EVT, 16'h1);
    wr(A_MODE, 16'h0001);
    cap_in = 1'b1; idle(3);
    rd(A_EVT, rv); chk("R7 disabled", rv, 16'h0);
    chk("R8 no irq", {15'd0, irq}, 16'd0);
    wr(A_CAP, 16'h1234);
    rd(A_CAP, rv); chk("R10 capture write ignored", rv, cap_val);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule